// File: doc/BRIEF.md
# External Bus Cycle Timing Controller

This block turns a simple request interface into the strobe timing of an asynchronous parallel memory bus with several chip-select spaces and a 16-bit data path. A requester raises `req` with a direction flag, a space index, an address and, for writes, the data. The block drives the selected active-low chip select, the read or write strobe, the address and the output data with its enable. It then answers with a one-cycle `rdy` pulse, carrying read data for reads.

Each access runs through four phases: a one-cycle setup phase, a strobe phase of `wait + 1` cycles, a one-cycle hold phase in which `rdy` is high, and idle. Between two accesses the block keeps the bus quiet for a number of cycles. The count comes from one of five settings, picked by the kind of the previous and next access and by whether the space changes. Spaces marked in a parameter mask can place their chip-select edges half a bus cycle outside the strobe. The chip-select output for these spaces is updated on the falling clock edge. All other spaces assert chip select exactly with the strobe.

The data bus is split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`, so that the pad ring can build the tri-state driver.

Top module: `ext_bus_timer`

## Requirements
- R1: While reset is high and in the cycle after it, every `mem_cs_n` bit, `mem_rd_n` and `mem_we_n` are 1, and `rdy` and `mem_dq_oe` are 0.
- R2: A request that is taken at the end of cycle k has its strobe (`mem_rd_n` when `req_wr`=0, `mem_we_n` when `req_wr`=1) low from cycle k+2 through cycle k+2+W. For reads, W is `cfg_rd_wait`. For writes, W is `cfg_wr_wait`, or `cfg_rd_wait` when `cfg_wr_follow`=1. The two strobes are never low together.
- R3: `rdy` is high for exactly one cycle: the cycle right after the strobe ends. For a read, `rdata` then holds the value of `mem_dq_in` at the rising edge that ends the strobe.
- R4: The quiet gap before an access is set by the previous and the next access. After any write it is `cfg_gap_wr`. For read then read it is `cfg_gap_rr_same` when the space index is equal and `cfg_gap_rr_diff` when it differs. For read then write it is `cfg_gap_rw_same` or `cfg_gap_rw_diff` in the same way.
- R5: If the hold cycle of the previous access is cycle H and the selected gap is G, a waiting request is taken no earlier than the end of cycle H+max(G,1). A request that arrives later is taken at the end of the cycle in which it first appears.
- R6: The first request after reset is taken at the end of the cycle in which it first appears, with no gap.
- R7: For a space whose bit is set in `HALF_MASK` (default spaces 0 and 5) and with `cfg_cs_lead`=1, chip select falls at the falling clock edge in the middle of the setup cycle, half a cycle before the strobe.
- R8: For such a space with `cfg_cs_lag`=1, chip select rises at the falling clock edge in the middle of the hold cycle, half a cycle after the strobe. With the setting at 0, it rises together with the strobe.
- R9: For a space whose `HALF_MASK` bit is clear, chip select is low exactly while the strobe is low, whatever `cfg_cs_lead` and `cfg_cs_lag` hold.
- R10: Only the `mem_cs_n` bit selected by `req_cs` ever goes low, and at most one bit is low at any time.
- R11: `mem_addr` holds the request address from the setup cycle through the hold cycle. For writes, `mem_dq_oe` is 1 and `mem_dq_out` holds the write data during the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, held with its fields until `rdy` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W (3) | Chip-select space index |
| req_addr | input | ADDR_W (20) | Access address |
| req_wdata | input | DATA_W (16) | Write data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (16) | Captured read data |
| cfg_gap_rr_same | input | GAP_W (4) | Gap, read then read, same space |
| cfg_gap_rr_diff | input | GAP_W (4) | Gap, read then read, other space |
| cfg_gap_rw_same | input | GAP_W (4) | Gap, read then write, same space |
| cfg_gap_rw_diff | input | GAP_W (4) | Gap, read then write, other space |
| cfg_gap_wr | input | GAP_W (4) | Gap after any write |
| cfg_rd_wait | input | WAIT_W (5) | Read wait states |
| cfg_wr_wait | input | WAIT_W (5) | Write wait states |
| cfg_wr_follow | input | 1 | Writes use the read wait count |
| cfg_cs_lead | input | 1 | Half-cycle chip-select lead for masked spaces |
| cfg_cs_lag | input | 1 | Half-cycle chip-select lag for masked spaces |
| mem_cs_n | output | NUM_CS (6) | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W (20) | Bus address |
| mem_dq_out | output | DATA_W (16) | Write data to the bus |
| mem_dq_oe | output | 1 | Output enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W (16) | Read data from the bus |

## Verification
For a request first seen in cycle k and taken at the end of cycle a, the strobe is due in cycles a+2 through a+2+W. `rdy` and the read data are due in cycle a+3+W. The half-cycle chip-select edges fall in the second half of cycle a+1 and the first half of cycle a+3+W. The bench works out a from its own record of the previous hold cycle and the gap setting. It writes the expected level of every strobe, chip select and `rdy` into a table indexed by half-cycle. It samples the outputs 2 ns after each rising and each falling edge, so each half of every cycle is compared against that table. Address, output enable and read data are checked in the first strobe cycle and in the hold cycle of each access.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } ebt_state_e;

  typedef enum logic [2:0] {
    GAP_RR_SAME = 3'd0,
    GAP_RR_DIFF = 3'd1,
    GAP_RW_SAME = 3'd2,
    GAP_RW_DIFF = 3'd3,
    GAP_WR      = 3'd4
  } ebt_gap_class_e;

  // Any write shares one class; reads split on direction and space change.
  function automatic ebt_gap_class_e ebt_classify(input logic prev_wr,
                                                  input logic next_wr,
                                                  input logic same_cs);
    if (prev_wr) return GAP_WR;
    if (next_wr) return same_cs ? GAP_RW_SAME : GAP_RW_DIFF;
    return same_cs ? GAP_RR_SAME : GAP_RR_DIFF;
  endfunction

endpackage

// File: rtl/ebt_gap_sel.sv
module ebt_gap_sel
  import ebt_pkg::*;
#(
  parameter int CS_W  = 3,
  parameter int GAP_W = 4
) (
  input  logic             prev_wr,
  input  logic [CS_W-1:0]  prev_cs,
  input  logic             next_wr,
  input  logic [CS_W-1:0]  next_cs,
  input  logic [GAP_W-1:0] gap_rr_same,
  input  logic [GAP_W-1:0] gap_rr_diff,
  input  logic [GAP_W-1:0] gap_rw_same,
  input  logic [GAP_W-1:0] gap_rw_diff,
  input  logic [GAP_W-1:0] gap_wr,
  output logic [GAP_W-1:0] need
);

  ebt_gap_class_e cls;

  always_comb begin
    cls = ebt_classify(prev_wr, next_wr, prev_cs == next_cs);
    unique case (cls)
      GAP_RR_SAME: need = gap_rr_same;
      GAP_RR_DIFF: need = gap_rr_diff;
      GAP_RW_SAME: need = gap_rw_same;
      GAP_RW_DIFF: need = gap_rw_diff;
      default:     need = gap_wr;
    endcase
  end

endmodule

// File: rtl/ebt_gap_timer.sv
module ebt_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_hold,
  input  logic             in_idle,
  input  logic             have_prev,
  input  logic [GAP_W-1:0] need,
  output logic             gap_ok
);

  localparam logic [GAP_W-1:0] SAT = {GAP_W{1'b1}};

  logic [GAP_W-1:0] elapsed_q;

  // Counts idle cycles since the last hold cycle; saturates so it never wraps.
  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
    end else if (in_hold) begin
      elapsed_q <= '0;
    end else if (in_idle && elapsed_q != SAT) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  // The current idle cycle is number elapsed_q+1; a zero setting still costs one cycle.
  assign gap_ok = !have_prev ||
                  (({1'b0, elapsed_q} + (GAP_W+1)'(1)) >= {1'b0, need});

endmodule

// File: rtl/ebt_seq.sv
module ebt_seq
  import ebt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int CS_W   = 3,
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              gap_ok,
  input  logic [WAIT_W-1:0] rd_wait,
  input  logic [WAIT_W-1:0] wr_wait,
  input  logic              wr_follow,
  input  logic [DATA_W-1:0] dq_in,
  output logic              in_idle,
  output logic              in_setup,
  output logic              in_hold,
  output logic              last_strobe,
  output logic              strobe_act,
  output logic              have_prev,
  output logic              cur_wr,
  output logic [CS_W-1:0]   cur_cs,
  output logic              rd_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata
);

  ebt_state_e        state_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [WAIT_W-1:0] wr_wait_eff;

  assign wr_wait_eff = wr_follow ? rd_wait : wr_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wcnt_q    <= '0;
      rd_n      <= 1'b1;
      we_n      <= 1'b1;
      strobe_act<= 1'b0;
      rdy       <= 1'b0;
      dq_oe     <= 1'b0;
      have_prev <= 1'b0;
      cur_wr    <= 1'b0;
      cur_cs    <= '0;
      addr      <= '0;
      dq_out    <= '0;
      rdata     <= '0;
    end else begin
      rdy <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req && gap_ok) begin
            state_q <= ST_SETUP;
            cur_wr  <= req_wr;
            cur_cs  <= req_cs;
            addr    <= req_addr;
            dq_out  <= req_wdata;
            dq_oe   <= req_wr;
            wcnt_q  <= req_wr ? wr_wait_eff : rd_wait;
          end
        end
        ST_SETUP: begin
          state_q    <= ST_STROBE;
          rd_n       <= cur_wr;
          we_n       <= !cur_wr;
          strobe_act <= 1'b1;
        end
        ST_STROBE: begin
          if (wcnt_q == '0) begin
            state_q    <= ST_HOLD;
            rd_n       <= 1'b1;
            we_n       <= 1'b1;
            strobe_act <= 1'b0;
            rdy        <= 1'b1;
            have_prev  <= 1'b1;
            if (!cur_wr) rdata <= dq_in;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          dq_oe   <= 1'b0;
        end
      endcase
    end
  end

  assign in_idle     = (state_q == ST_IDLE);
  assign in_setup    = (state_q == ST_SETUP);
  assign in_hold     = (state_q == ST_HOLD);
  assign last_strobe = (state_q == ST_STROBE) && (wcnt_q == '0);

endmodule

// File: rtl/ebt_cs_shape.sv
module ebt_cs_shape #(
  parameter int                NUM_CS    = 6,
  parameter int                CS_W      = 3,
  parameter logic [NUM_CS-1:0] HALF_MASK = 6'b100001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CS_W-1:0]   sel,
  input  logic              strobe_act,
  input  logic              in_setup,
  input  logic              last_strobe,
  input  logic              cfg_lead,
  input  logic              cfg_lag,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic hit;
    assign hit = (sel == CS_W'(i));

    if (HALF_MASK[i]) begin : g_half
      logic lead_q;
      logic lag_q;
      // Falling-edge flops: lead covers mid-setup to mid-first-strobe,
      // lag covers mid-last-strobe to mid-hold.
      always_ff @(negedge clk) begin
        if (rst) begin
          lead_q <= 1'b0;
          lag_q  <= 1'b0;
        end else begin
          lead_q <= hit && in_setup && cfg_lead;
          lag_q  <= hit && last_strobe && cfg_lag;
        end
      end
      assign cs_n[i] = !((hit && strobe_act) || lead_q || lag_q);
    end else begin : g_plain
      assign cs_n[i] = !(hit && strobe_act);
    end
  end

endmodule

// File: rtl/ext_bus_timer.sv
module ext_bus_timer #(
  parameter int                NUM_CS    = 6,
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter int                GAP_W     = 4,
  parameter int                WAIT_W    = 5,
  parameter logic [NUM_CS-1:0] HALF_MASK = 6'b100001,
  localparam int               CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata,
  input  logic [GAP_W-1:0]  cfg_gap_rr_same,
  input  logic [GAP_W-1:0]  cfg_gap_rr_diff,
  input  logic [GAP_W-1:0]  cfg_gap_rw_same,
  input  logic [GAP_W-1:0]  cfg_gap_rw_diff,
  input  logic [GAP_W-1:0]  cfg_gap_wr,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  input  logic              cfg_wr_follow,
  input  logic              cfg_cs_lead,
  input  logic              cfg_cs_lag,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  logic             in_idle, in_setup, in_hold, last_strobe, strobe_act;
  logic             have_prev, cur_wr, gap_ok;
  logic [CS_W-1:0]  cur_cs;
  logic [GAP_W-1:0] need;

  ebt_gap_sel #(.CS_W(CS_W), .GAP_W(GAP_W)) u_gap_sel (
    .prev_wr     (cur_wr),
    .prev_cs     (cur_cs),
    .next_wr     (req_wr),
    .next_cs     (req_cs),
    .gap_rr_same (cfg_gap_rr_same),
    .gap_rr_diff (cfg_gap_rr_diff),
    .gap_rw_same (cfg_gap_rw_same),
    .gap_rw_diff (cfg_gap_rw_diff),
    .gap_wr      (cfg_gap_wr),
    .need        (need)
  );

  ebt_gap_timer #(.GAP_W(GAP_W)) u_gap_timer (
    .clk       (clk),
    .rst       (rst),
    .in_hold   (in_hold),
    .in_idle   (in_idle),
    .have_prev (have_prev),
    .need      (need),
    .gap_ok    (gap_ok)
  );

  ebt_seq #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CS_W   (CS_W),
    .WAIT_W (WAIT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_wr      (req_wr),
    .req_cs      (req_cs),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .gap_ok      (gap_ok),
    .rd_wait     (cfg_rd_wait),
    .wr_wait     (cfg_wr_wait),
    .wr_follow   (cfg_wr_follow),
    .dq_in       (mem_dq_in),
    .in_idle     (in_idle),
    .in_setup    (in_setup),
    .in_hold     (in_hold),
    .last_strobe (last_strobe),
    .strobe_act  (strobe_act),
    .have_prev   (have_prev),
    .cur_wr      (cur_wr),
    .cur_cs      (cur_cs),
    .rd_n        (mem_rd_n),
    .we_n        (mem_we_n),
    .addr        (mem_addr),
    .dq_out      (mem_dq_out),
    .dq_oe       (mem_dq_oe),
    .rdy         (rdy),
    .rdata       (rdata)
  );

  ebt_cs_shape #(
    .NUM_CS    (NUM_CS),
    .CS_W      (CS_W),
    .HALF_MASK (HALF_MASK)
  ) u_cs_shape (
    .clk         (clk),
    .rst         (rst),
    .sel         (cur_cs),
    .strobe_act  (strobe_act),
    .in_setup    (in_setup),
    .last_strobe (last_strobe),
    .cfg_lead    (cfg_cs_lead),
    .cfg_lag     (cfg_cs_lag),
    .cs_n        (mem_cs_n)
  );

endmodule

// File: rtl/ebt_checks.sv
module ebt_checks #(
  parameter int                NUM_CS    = 6,
  parameter int                ADDR_W    = 20,
  parameter logic [NUM_CS-1:0] HALF_MASK = 6'b100001
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_rd_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              rdy
);

  logic strobe_on;
  assign strobe_on = !mem_rd_n || !mem_we_n;

  a_r10_single_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_we_n));

  a_r3_rdy_single: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  a_r3_rdy_on_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_rd_n) || $rose(mem_we_n)) |-> rdy);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe_on && $past(strobe_on)) |-> $stable(mem_addr));

  a_r11_oe_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_plain_chk
    if (!HALF_MASK[i]) begin : g_on
      // R9: a space without half-cycle offsets is selected only under a strobe
      a_r9_plain_cs: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n[i] |-> strobe_on);
    end
  end

endmodule

bind ext_bus_timer ebt_checks #(
  .NUM_CS    (NUM_CS),
  .ADDR_W    (ADDR_W),
  .HALF_MASK (HALF_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_cs_n  (mem_cs_n),
  .mem_rd_n  (mem_rd_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe),
  .rdy       (rdy)
);

// File: tb/ext_bus_timer_tb.sv
module ext_bus_timer_tb;

  localparam int NUM_CS = 6;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int GAP_W  = 4;
  localparam int WAIT_W = 5;
  localparam int CS_W   = 3;
  localparam logic [NUM_CS-1:0] HALF = 6'b100001;
  localparam int MAXH = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [CS_W-1:0]   req_cs = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, mem_dq_in = '0;
  logic [GAP_W-1:0]  g_rrs = 4'd4, g_rrd = 4'd6, g_rws = 4'd3, g_rwd = 4'd5, g_wr = 4'd7;
  logic [WAIT_W-1:0] rd_w = 5'd2, wr_w = 5'd1;
  logic wr_follow = 1'b0, lead = 1'b1, lag = 1'b1;
  logic rdy, mem_rd_n, mem_we_n, mem_dq_oe;
  logic [DATA_W-1:0] rdata, mem_dq_out;
  logic [NUM_CS-1:0] mem_cs_n;
  logic [ADDR_W-1:0] mem_addr;

  always #5 clk = ~clk;

  ext_bus_timer u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata),
    .cfg_gap_rr_same(g_rrs), .cfg_gap_rr_diff(g_rrd), .cfg_gap_rw_same(g_rws),
    .cfg_gap_rw_diff(g_rwd), .cfg_gap_wr(g_wr), .cfg_rd_wait(rd_w),
    .cfg_wr_wait(wr_w), .cfg_wr_follow(wr_follow), .cfg_cs_lead(lead),
    .cfg_cs_lag(lag), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  // expected levels per half-cycle (index 2*cycle, 2*cycle+1)
  logic [NUM_CS-1:0] exp_cs [MAXH];
  bit exp_rd [MAXH];
  bit exp_we [MAXH];
  bit exp_rdy [MAXH];

  // bench-side record of the previous access
  bit have_prev = 1'b0;
  bit prev_wr = 1'b0;
  int prev_cs = 0;
  int prev_hold = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare(input int h);
    if (h >= MAXH) return;
    check(mem_rd_n == exp_rd[h], "R2 read strobe", mem_rd_n, exp_rd[h]);
    check(mem_we_n == exp_we[h], "R2 write strobe", mem_we_n, exp_we[h]);
    check(mem_cs_n == exp_cs[h], "R10 chip selects (R7 R8 R9 timing)", mem_cs_n, exp_cs[h]);
    check(rdy == exp_rdy[h], "R3 rdy pulse", rdy, exp_rdy[h]);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (mon_on) compare(2 * cyc);
      @(negedge clk); #2;
      if (mon_on) compare(2 * cyc + 1);
    end
  end

  function automatic int gap_for(input bit wr, input int cs);
    if (prev_wr) return int'(g_wr);
    if (wr) return (cs == prev_cs) ? int'(g_rws) : int'(g_rwd);
    return (cs == prev_cs) ? int'(g_rrs) : int'(g_rrd);
  endfunction

  // Called at 1 ns after a rising edge; returns at 1 ns after the edge ending the hold cycle.
  task automatic access(input bit wr, input int cs, input logic [ADDR_W-1:0] ad,
                        input logic [DATA_W-1:0] dat, input string tag);
    int k, a, w, hold, g;
    k = cyc;
    if (!have_prev) a = k;
    else begin
      g = gap_for(wr, cs);
      if (g < 1) g = 1;
      a = (prev_hold + g > k) ? prev_hold + g : k;
    end
    w = wr ? int'(wr_follow ? rd_w : wr_w) : int'(rd_w);
    hold = a + 3 + w;
    for (int s = a + 2; s <= a + 2 + w; s++) begin
      for (int p = 0; p < 2; p++) begin
        if (wr) exp_we[2*s+p] = 1'b0; else exp_rd[2*s+p] = 1'b0;
        exp_cs[2*s+p][cs] = 1'b0;
      end
    end
    if (HALF[cs] && lead) exp_cs[2*(a+1)+1][cs] = 1'b0;
    if (HALF[cs] && lag)  exp_cs[2*hold][cs] = 1'b0;
    exp_rdy[2*hold] = 1'b1;
    exp_rdy[2*hold+1] = 1'b1;
    req = 1'b1; req_wr = wr; req_cs = CS_W'(cs); req_addr = ad; req_wdata = dat;
    mem_dq_in = ~dat;
    while (cyc < hold) begin
      @(posedge clk); #1;
      if (cyc == a + 2) begin
        check(mem_addr == ad, {tag, " R11 address in strobe"}, mem_addr, ad);
        check(mem_dq_oe == wr, {tag, " R11 output enable"}, mem_dq_oe, wr);
        if (wr) check(mem_dq_out == dat, {tag, " R11 write data"}, mem_dq_out, dat);
      end
    end
    check(rdy == 1'b1, {tag, " R3 rdy in hold cycle"}, rdy, 1);
    check(mem_addr == ad, {tag, " R11 address in hold"}, mem_addr, ad);
    if (!wr) check(rdata == ~dat, {tag, " R3 read data"}, rdata, ~dat);
    else check(mem_dq_oe == 1'b1, {tag, " R11 enable in hold"}, mem_dq_oe, 1);
    @(posedge clk); #1;
    req = 1'b0;
    have_prev = 1'b1; prev_wr = wr; prev_cs = cs; prev_hold = hold;
  endtask

  initial begin
    for (int h = 0; h < MAXH; h++) begin
      exp_cs[h] = '1; exp_rd[h] = 1'b1; exp_we[h] = 1'b1; exp_rdy[h] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(mem_cs_n == '1, "R1 chip selects in reset", mem_cs_n, 6'h3f);
    check(mem_rd_n && mem_we_n, "R1 strobes in reset", {mem_rd_n, mem_we_n}, 2'b11);
    check(!rdy && !mem_dq_oe, "R1 rdy and enable in reset", {rdy, mem_dq_oe}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    mon_on = 1'b1;

    access(1'b0, 1, 20'h01234, 16'h1111, "R6 first read cs1");
    access(1'b0, 1, 20'h01235, 16'h2222, "R4 read-read same");
    access(1'b0, 2, 20'h02000, 16'h3333, "R4 read-read diff");
    access(1'b1, 2, 20'h02004, 16'h4444, "R4 write after read same");
    access(1'b0, 0, 20'h00010, 16'h5555, "R7 R8 read cs0 after write");
    access(1'b1, 5, 20'h50000, 16'h6666, "R4 write after read diff cs5");
    access(1'b1, 5, 20'h50002, 16'h7777, "R4 write after write");
    rd_w = 5'd3; wr_follow = 1'b1;
    access(1'b1, 3, 20'h30000, 16'h8888, "R2 write wait follows read");
    wr_follow = 1'b0;
    repeat (12) @(posedge clk);
    #1;
    access(1'b0, 4, 20'h40000, 16'h9999, "R5 late request");
    g_rrs = 4'd0;
    access(1'b0, 4, 20'h40001, 16'haaaa, "R5 zero gap setting");
    lead = 1'b0; lag = 1'b1; rd_w = 5'd0;
    access(1'b0, 0, 20'h00020, 16'hbbbb, "R8 lag only cs0");
    lead = 1'b1; lag = 1'b0;
    access(1'b0, 0, 20'h00022, 16'hcccc, "R7 lead only cs0");
    lead = 1'b1; lag = 1'b1; rd_w = 5'd1;
    access(1'b0, 3, 20'h30010, 16'hdddd, "R9 plain space ignores offsets");
    repeat (10) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule